// File: doc/BRIEF.md
# Read Command Pacing Throttle

This block sits in the read path of a transfer engine, between the unit that produces read commands and the system bus. Within one transfer request it forwards read commands with at least a programmable number of idle cycles between two accepted commands. This keeps a single engine from filling the command buffer of a shared slave. A low-priority engine is given a long spacing and a high-priority engine a short spacing or none. Software can change the spacing at any time.

The first read of every transfer request goes out without delay, because a start strobe clears any pending spacing. The write command path runs beside the read path and passes straight through. Nothing in the block delays it.

Top module: `rdrl_read_throttle`

## Requirements
- R1: After reset no spacing is pending. A valid read command is presented downstream in the first cycle after reset, whether or not downstream is ready.
- R2: With spacing code 0, accepted read commands may follow each other in consecutive cycles, with zero idle cycles between handshakes.
- R3: A nonzero 3-bit spacing code k gives exactly 2^(k+1) idle cycles after an accepted read command: code 1 gives 4, code 2 gives 8, and so on up to code 7, which gives 256. The next command can then be accepted.
- R4: While spacing is pending, the downstream read valid and the upstream read ready are both held low.
- R5: The spacing length is taken from the code present in the cycle of the handshake. A code change during a pending spacing does not shorten or lengthen that spacing. It applies from the next handshake onward.
- R6: In a cycle where the transfer-start strobe is high, pending spacing is dropped in that same cycle, so the first read of the new request passes at once.
- R7: A read handshake in the same cycle as the transfer-start strobe starts a full new spacing, using the current code.
- R8: The write path never stalls on read spacing. Downstream write valid equals upstream write valid, upstream write ready equals downstream write ready, and the write payload is unchanged, in every cycle.
- R9: The read command payload reaches downstream unchanged.
- R10: Spacing counts only from a completed handshake. While downstream refuses a command, valid stays high, no spacing builds up, and the command is accepted as soon as ready rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel_i | input | 3 | Spacing code (0 = none, k = 2^(k+1) idle cycles) |
| xfer_start_i | input | 1 | One-cycle strobe at the start of a transfer request |
| up_rd_valid_i | input | 1 | Upstream read command valid |
| up_rd_ready_o | output | 1 | Upstream read command ready |
| up_rd_cmd_i | input | 32 | Upstream read command payload |
| dn_rd_valid_o | output | 1 | Downstream read command valid |
| dn_rd_ready_i | input | 1 | Downstream read command ready |
| dn_rd_cmd_o | output | 32 | Downstream read command payload |
| up_wr_valid_i | input | 1 | Upstream write command valid |
| up_wr_ready_o | output | 1 | Upstream write command ready |
| up_wr_cmd_i | input | 32 | Upstream write command payload |
| dn_wr_valid_o | output | 1 | Downstream write command valid |
| dn_wr_ready_i | input | 1 | Downstream write command ready |
| dn_wr_cmd_o | output | 32 | Downstream write command payload |

## Verification
The assertions check several rules on every cycle. After a handshake with a nonzero spacing, the next cycle is closed unless a start strobe arrives. A strobe with a valid command always opens the read path. Code 0 never leaves spacing pending. The spacing counter stays within its largest value and counts down by exactly one. The write path follows its inputs. Other behaviours can only be shown by the bench's scenarios, which compare against a cycle-by-cycle reference model: the exact idle count for each of the eight codes, that a code written in the middle of a spacing has no effect on it, and how a strobe that coincides with a handshake is handled.

// File: rtl/rdrl_pkg.sv
`timescale 1ns/1ps
package rdrl_pkg;

   // How a spacing code maps to an idle-cycle count.
   typedef enum logic [0:0] {
      GAP_EXP = 1'b0,   // code k -> 2^(k+BASE_SHIFT), code 0 -> 0
      GAP_LIN = 1'b1    // code k -> k*LIN_STEP
   } gap_enc_e;

   function automatic int unsigned gap_of(int unsigned code, gap_enc_e enc,
                                          int unsigned base_shift,
                                          int unsigned lin_step);
      if (code == 0) return 0;
      if (enc == GAP_EXP) return 32'd1 << (code + base_shift);
      return code * lin_step;
   endfunction

endpackage

// File: rtl/rdrl_gap_decode.sv
`timescale 1ns/1ps
module rdrl_gap_decode
   import rdrl_pkg::*;
#(
   parameter int unsigned RATE_W     = 3,
   parameter int unsigned CNT_W      = 9,
   parameter gap_enc_e    ENC        = GAP_EXP,
   parameter int unsigned BASE_SHIFT = 1,
   parameter int unsigned LIN_STEP   = 4
) (
   input  logic [RATE_W-1:0] rate_i,
   output logic [CNT_W-1:0]  gap_o
);
   localparam int unsigned NCODE = 1 << RATE_W;

   generate
      if (ENC == GAP_EXP) begin : g_exp
         logic [CNT_W-1:0] tbl [NCODE];
         for (genvar g = 0; g < NCODE; g++) begin : g_ent
            assign tbl[g] = CNT_W'(gap_of(g, ENC, BASE_SHIFT, LIN_STEP));
         end
         assign gap_o = tbl[rate_i];
      end else begin : g_lin
         assign gap_o = CNT_W'(rate_i) * CNT_W'(LIN_STEP);
      end
   endgenerate

endmodule

// File: rtl/rdrl_gap_timer.sv
`timescale 1ns/1ps
module rdrl_gap_timer #(
   parameter int unsigned CNT_W   = 9,
   parameter int unsigned MAX_GAP = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             clear_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             busy_o
);
   logic [CNT_W-1:0] cnt_q;

   // A handshake reloads the counter; the start strobe drops it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= load_val_i;
      else if (clear_i)        cnt_q <= '0;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX_GAP));

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) && !load_i && !clear_i |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/rdrl_rd_gate.sv
`timescale 1ns/1ps
module rdrl_rd_gate #(
   parameter int unsigned CMD_W     = 32,
   parameter bit          MASK_IDLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_i,
   input  logic             up_valid_i,
   output logic             up_ready_o,
   input  logic [CMD_W-1:0] up_cmd_i,
   output logic             dn_valid_o,
   input  logic             dn_ready_i,
   output logic [CMD_W-1:0] dn_cmd_o,
   output logic             fire_o
);
   assign dn_valid_o = up_valid_i & ~hold_i;
   assign up_ready_o = dn_ready_i & ~hold_i;
   assign fire_o     = dn_valid_o & dn_ready_i;

   generate
      if (MASK_IDLE) begin : g_mask
         assign dn_cmd_o = dn_valid_o ? up_cmd_i : '0;
      end else begin : g_pass
         assign dn_cmd_o = up_cmd_i;
      end
   endgenerate

   // R10
   rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid_o |-> up_valid_i);

   // R9
   rd_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid_o |-> dn_cmd_o == up_cmd_i);

endmodule

// File: rtl/rdrl_wr_pass.sv
`timescale 1ns/1ps
module rdrl_wr_pass #(
   parameter int unsigned CMD_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_valid_i,
   output logic             up_ready_o,
   input  logic [CMD_W-1:0] up_cmd_i,
   output logic             dn_valid_o,
   input  logic             dn_ready_i,
   output logic [CMD_W-1:0] dn_cmd_o
);
   assign dn_valid_o = up_valid_i;
   assign up_ready_o = dn_ready_i;
   assign dn_cmd_o   = up_cmd_i;

   // R8
   wr_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid_i && dn_ready_i |-> dn_valid_o && up_ready_o && dn_cmd_o == up_cmd_i);

endmodule

// File: rtl/rdrl_read_throttle.sv
`timescale 1ns/1ps
module rdrl_read_throttle
   import rdrl_pkg::*;
#(
   parameter int unsigned RATE_W     = 3,
   parameter int unsigned RD_CMD_W   = 32,
   parameter int unsigned WR_CMD_W   = 32,
   parameter gap_enc_e    ENC        = GAP_EXP,
   parameter int unsigned BASE_SHIFT = 1,
   parameter int unsigned LIN_STEP   = 4,
   parameter bit          MASK_IDLE  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [RATE_W-1:0]   rate_sel_i,
   input  logic                xfer_start_i,
   input  logic                up_rd_valid_i,
   output logic                up_rd_ready_o,
   input  logic [RD_CMD_W-1:0] up_rd_cmd_i,
   output logic                dn_rd_valid_o,
   input  logic                dn_rd_ready_i,
   output logic [RD_CMD_W-1:0] dn_rd_cmd_o,
   input  logic                up_wr_valid_i,
   output logic                up_wr_ready_o,
   input  logic [WR_CMD_W-1:0] up_wr_cmd_i,
   output logic                dn_wr_valid_o,
   input  logic                dn_wr_ready_i,
   output logic [WR_CMD_W-1:0] dn_wr_cmd_o
);
   localparam int unsigned NCODE   = 1 << RATE_W;
   localparam int unsigned MAX_GAP = gap_of(NCODE - 1, ENC, BASE_SHIFT, LIN_STEP);
   localparam int unsigned CNT_W   = (MAX_GAP < 2) ? 1 : $clog2(MAX_GAP + 1);

   generate
      if (RATE_W < 1 || RATE_W > 5) begin : g_bad_rate_w
         $error("rdrl_read_throttle: RATE_W must be within 1..5");
      end
      if (ENC == GAP_EXP && (NCODE - 1 + BASE_SHIFT) > 20) begin : g_bad_shift
         $error("rdrl_read_throttle: largest spacing too wide");
      end
      if (RD_CMD_W < 1 || WR_CMD_W < 1) begin : g_bad_cmd_w
         $error("rdrl_read_throttle: command widths must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] load_gap;
   logic             gap_busy;
   logic             rd_hold;
   logic             rd_fire;

   rdrl_gap_decode #(
      .RATE_W(RATE_W), .CNT_W(CNT_W), .ENC(ENC),
      .BASE_SHIFT(BASE_SHIFT), .LIN_STEP(LIN_STEP)
   ) decode_i (
      .rate_i (rate_sel_i),
      .gap_o  (load_gap)
   );

   rdrl_gap_timer #(
      .CNT_W(CNT_W), .MAX_GAP(MAX_GAP)
   ) timer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (rd_fire),
      .clear_i    (xfer_start_i),
      .load_val_i (load_gap),
      .busy_o     (gap_busy)
   );

   // The start strobe opens the path in its own cycle.
   assign rd_hold = gap_busy & ~xfer_start_i;

   rdrl_rd_gate #(
      .CMD_W(RD_CMD_W), .MASK_IDLE(MASK_IDLE)
   ) rd_gate_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold_i     (rd_hold),
      .up_valid_i (up_rd_valid_i),
      .up_ready_o (up_rd_ready_o),
      .up_cmd_i   (up_rd_cmd_i),
      .dn_valid_o (dn_rd_valid_o),
      .dn_ready_i (dn_rd_ready_i),
      .dn_cmd_o   (dn_rd_cmd_o),
      .fire_o     (rd_fire)
   );

   rdrl_wr_pass #(
      .CMD_W(WR_CMD_W)
   ) wr_pass_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .up_valid_i (up_wr_valid_i),
      .up_ready_o (up_wr_ready_o),
      .up_cmd_i   (up_wr_cmd_i),
      .dn_valid_o (dn_wr_valid_o),
      .dn_ready_i (dn_wr_ready_i),
      .dn_cmd_o   (dn_wr_cmd_o)
   );

   // R4
   gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire && (load_gap != '0) |=> xfer_start_i || (!dn_rd_valid_o && !up_rd_ready_o));

   // R6
   start_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start_i && up_rd_valid_i |-> dn_rd_valid_o);

   // R2
   zero_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire && (rate_sel_i == '0) |=> !gap_busy);

   // R7
   start_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire && xfer_start_i && (load_gap != '0) |=> gap_busy);

endmodule

// File: tb/rdrl_read_throttle_tb_top.sv
`timescale 1ns/1ps
module rdrl_read_throttle_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  rate_sel = '0;
   logic        xfer_start = 1'b0;
   logic        up_rd_valid = 1'b0;
   logic        up_rd_ready;
   logic [31:0] up_rd_cmd = '0;
   logic        dn_rd_valid;
   logic        dn_rd_ready = 1'b0;
   logic [31:0] dn_rd_cmd;
   logic        up_wr_valid = 1'b0;
   logic        up_wr_ready;
   logic [31:0] up_wr_cmd = '0;
   logic        dn_wr_valid;
   logic        dn_wr_ready = 1'b0;
   logic [31:0] dn_wr_cmd;

   always #2 clk = ~clk;   // 250 MHz

   rdrl_read_throttle dut_i (
      .clk(clk), .rst_n(rst_n), .rate_sel_i(rate_sel), .xfer_start_i(xfer_start),
      .up_rd_valid_i(up_rd_valid), .up_rd_ready_o(up_rd_ready), .up_rd_cmd_i(up_rd_cmd),
      .dn_rd_valid_o(dn_rd_valid), .dn_rd_ready_i(dn_rd_ready), .dn_rd_cmd_o(dn_rd_cmd),
      .up_wr_valid_i(up_wr_valid), .up_wr_ready_o(up_wr_ready), .up_wr_cmd_i(up_wr_cmd),
      .dn_wr_valid_o(dn_wr_valid), .dn_wr_ready_i(dn_wr_ready), .dn_wr_cmd_o(dn_wr_cmd)
   );

   int n_chk = 0, n_fail = 0;
   int ref_cnt = 0;
   int cyc = 0, last_fire = 0, last_gap = -1;
   bit fired_now, obs_dv, obs_ur, obs_wv, obs_wr;

   function automatic int exp_gap(int c);
      return (c == 0) ? 0 : (1 << (c + 1));
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // One clock: compare every output with the reference model, then advance it.
   task automatic step();
      bit hold;
      bit e_dv, e_ur;
      up_rd_cmd = 32'h5A5A_0000 ^ (cyc * 32'h9E37);
      up_wr_cmd = 32'hC3C3_0000 ^ (cyc * 32'h0101);
      #1;
      hold = (ref_cnt != 0) && !xfer_start;
      e_dv = up_rd_valid && !hold;
      e_ur = dn_rd_ready && !hold;
      chk(dn_rd_valid === e_dv, "R4 rd valid", dn_rd_valid, e_dv);
      chk(up_rd_ready === e_ur, "R4 rd ready", up_rd_ready, e_ur);
      chk(dn_rd_cmd === up_rd_cmd, "R9 rd payload", dn_rd_cmd, up_rd_cmd);
      chk(dn_wr_valid === up_wr_valid, "R8 wr valid", dn_wr_valid, up_wr_valid);
      chk(up_wr_ready === dn_wr_ready, "R8 wr ready", up_wr_ready, dn_wr_ready);
      chk(dn_wr_cmd === up_wr_cmd, "R8 wr payload", dn_wr_cmd, up_wr_cmd);
      obs_dv = dn_rd_valid; obs_ur = up_rd_ready;
      obs_wv = dn_wr_valid; obs_wr = up_wr_ready;
      fired_now = dn_rd_valid && dn_rd_ready;
      if (fired_now) begin
         last_gap  = cyc - last_fire - 1;
         last_fire = cyc;
      end
      @(posedge clk);
      if (!rst_n) ref_cnt = 0;
      else if (up_rd_valid && dn_rd_ready && !hold) ref_cnt = exp_gap(int'(rate_sel));
      else if (xfer_start) ref_cnt = 0;
      else if (ref_cnt > 0) ref_cnt--;
      cyc++;
      @(negedge clk);
   endtask

   task automatic wait_fire();
      int n = 0;
      do begin step(); n++; end while (!fired_now && n < 1000);
   endtask

   task automatic start_fire();
      xfer_start = 1'b1; up_rd_valid = 1'b1; dn_rd_ready = 1'b1;
      step();
      chk(fired_now, "R6 first read of request", fired_now, 1);
      xfer_start = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      repeat (3) step();
      rst_n = 1'b1;

      // R1: fresh out of reset, valid passes even with ready low
      up_rd_valid = 1'b1; dn_rd_ready = 1'b0;
      step();
      chk(obs_dv, "R1 valid after reset", obs_dv, 1);

      // R10: a refused command builds no spacing
      rate_sel = 3'd2;
      repeat (5) begin
         step();
         chk(obs_dv && !fired_now, "R10 held while refused", obs_dv, 1);
      end
      dn_rd_ready = 1'b1;
      step();
      chk(fired_now, "R10 accepted when ready rises", fired_now, 1);
      wait_fire();
      chk(last_gap == 8, "R10 gap after accept", last_gap, 8);

      // R2 / R3: every code
      for (int c = 0; c < 8; c++) begin
         rate_sel = 3'(c);
         start_fire();
         wait_fire();
         if (c == 0) chk(last_gap == 0, "R2 back to back", last_gap, 0);
         else        chk(last_gap == exp_gap(c), "R3 gap per code", last_gap, exp_gap(c));
      end

      // R4: closed right after a handshake
      rate_sel = 3'd3;
      start_fire();
      step();
      chk(!obs_dv, "R4 valid low in gap", obs_dv, 0);
      chk(!obs_ur, "R4 ready low in gap", obs_ur, 0);

      // R8: writes pass during a read gap
      up_wr_valid = 1'b1; dn_wr_ready = 1'b1;
      step();
      chk(obs_wv && obs_wr, "R8 write during gap", obs_wv && obs_wr, 1);
      up_wr_valid = 1'b0; dn_wr_ready = 1'b0;

      // R5: a code change mid-gap waits for the next gap
      rate_sel = 3'd7;
      start_fire();
      repeat (3) step();
      rate_sel = 3'd1;
      wait_fire();
      chk(last_gap == 256, "R5 current gap unchanged", last_gap, 256);
      wait_fire();
      chk(last_gap == 4, "R5 new code on next gap", last_gap, 4);

      // R6 / R7: strobe mid-gap, coinciding with a handshake
      rate_sel = 3'd3;
      start_fire();
      repeat (5) step();
      start_fire();
      wait_fire();
      chk(last_gap == 16, "R7 gap from strobe handshake", last_gap, 16);

      up_rd_valid = 1'b0;
      repeat (4) step();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule